// File: doc/BRIEF.md
# Receive Mailbox Overwrite Arbiter

This block picks the storage slot for a freshly received frame whose identifier has already been matched against a bank of receive mailboxes. Each cycle that a frame is presented, the block takes a vector with one bit per mailbox marking the mailboxes the frame fits. It searches that vector from the top index downward and names the winning mailbox on a one-cycle store strobe. Each mailbox has a pending flag, which means it holds an unread frame, and a lost flag, which means an unread frame was replaced. Each mailbox also has a bit in a software-written protection mask. A mailbox that is still pending and is protected is passed over, and the search moves on to the next lower match. A mailbox that is pending and unprotected is overwritten, and its lost flag is raised. When no usable mailbox remains, the frame is dropped silently.

Software clears pending flags with one strobe per mailbox. It programs the protection mask, an interrupt-enable mask and an interrupt-level mask through a small word-wide register port. The level mask sends each mailbox's pending condition to one of two interrupt lines.

Top module: `rx_ovw_arbiter`

## Requirements
- R1: After reset, the pending, lost, protection, level and enable state all read as zero, and both interrupt lines are low.
- R2: For a valid frame, the chosen mailbox is the highest-index matching mailbox that is either not pending or not protected. In the same cycle `store_vld` is 1 and `store_idx` carries that index. From the next cycle that mailbox's pending flag reads 1.
- R3: A matching mailbox that is both pending and protected keeps its frame, and the search continues to lower-index matches.
- R4: When the chosen mailbox was already pending, the new frame replaces the old one and that mailbox's lost flag is set from the next cycle.
- R5: When no matching mailbox is usable, `store_vld` stays 0 and no pending or lost flag changes.
- R6: A clear strobe on `clr_pend[n]` clears both the pending and lost flags of mailbox n. If a store to mailbox n happens in the same cycle, pending stays 1 and lost takes the value set by that store.
- R7: `irq_line1` is the OR of pending AND enabled over mailboxes whose level bit is 1. `irq_line0` is the same OR over mailboxes whose level bit is 0.
- R8: A register write takes effect only when all four `wr_be` bits are 1; any narrower write leaves the register unchanged. Register addresses are: 0 protection, 1 level, 2 interrupt enable, 3 pending (read only), 4 lost (read only). Bit n of each register belongs to mailbox n, and bits at or above the mailbox count read 0.
- R9: With `frame_vld` low, no store happens, whatever the match vector is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | A matched frame is offered this cycle |
| match | input | NUM_MB | Mailboxes the offered frame fits |
| clr_pend | input | NUM_MB | Software clear of pending and lost flags, per mailbox |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 3 | Register write address |
| wr_be | input | 4 | Byte enables; only all-ones is accepted |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| store_vld | output | 1 | One-cycle store strobe |
| store_idx | output | IDX_W | Mailbox chosen for the store |
| irq_line0 | output | 1 | Interrupt line for level-bit-0 mailboxes |
| irq_line1 | output | 1 | Interrupt line for level-bit-1 mailboxes |

## Verification
The bench builds the block with four mailboxes. At that size it can visit every combination of match vector, prior pending pattern and protection mask (4096 cases). That covers every ordering of skipped, overwritten and empty slots, including the case where every match is blocked. The interrupt routing is swept over every pending, level and enable pattern for the four mailboxes. Byte-enable rejection, clear and store in the same cycle, and an idle frame strobe are each checked directly.

// File: rtl/rxarb_pkg.sv
package rxarb_pkg;
    localparam int REG_W  = 32;
    localparam int BE_W   = REG_W / 8;
    localparam int ADDR_W = 3;
    localparam int MB_MAX = 32;
    localparam int SLOT_W = $clog2(MB_MAX);

    typedef enum logic [ADDR_W-1:0] {
        REG_PROT  = 3'd0,
        REG_LEVEL = 3'd1,
        REG_IEN   = 3'd2,
        REG_PEND  = 3'd3,
        REG_LOST  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic              ovw;
        logic [SLOT_W-1:0] slot;
    } pick_t;

    function automatic logic whole_word(input logic [BE_W-1:0] be);
        return &be;
    endfunction
endpackage

// File: rtl/rxarb_select.sv
module rxarb_select
    import rxarb_pkg::*;
#(
    parameter int NUM_MB = 32
) (
    input  logic [NUM_MB-1:0] match,
    input  logic [NUM_MB-1:0] pend,
    input  logic [NUM_MB-1:0] prot,
    output pick_t             pick
);
    // Ascending scan: the last usable match seen is the highest index.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (match[i] && !(pend[i] && prot[i])) begin
                pick.hit  = 1'b1;
                pick.ovw  = pend[i];
                pick.slot = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/rxarb_flags.sv
module rxarb_flags
    import rxarb_pkg::*;
#(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_vld,
    input  logic [SLOT_W-1:0] store_slot,
    input  logic              store_ovw,
    input  logic [NUM_MB-1:0] clr,
    output logic [NUM_MB-1:0] pend_q,
    output logic [NUM_MB-1:0] lost_q
);
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic here;
        logic p_r, l_r;
        assign here = store_vld && (store_slot == SLOT_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                p_r <= 1'b0;
                l_r <= 1'b0;
            end else begin
                p_r <= (p_r & ~clr[g]) | here;
                l_r <= (l_r & ~clr[g]) | (here & store_ovw);
            end
        end
        assign pend_q[g] = p_r;
        assign lost_q[g] = l_r;
    end
endmodule

// File: rtl/rxarb_regs.sv
module rxarb_regs
    import rxarb_pkg::*;
#(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [NUM_MB-1:0] prot_q,
    output logic [NUM_MB-1:0] lvl_q,
    output logic [NUM_MB-1:0] ien_q
);
    logic     take;
    reg_sel_e sel;
    assign take = wr_en && whole_word(wr_be);
    assign sel  = reg_sel_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
            lvl_q  <= '0;
            ien_q  <= '0;
        end else if (take) begin
            case (sel)
                REG_PROT:  prot_q <= wr_data[NUM_MB-1:0];
                REG_LEVEL: lvl_q  <= wr_data[NUM_MB-1:0];
                REG_IEN:   ien_q  <= wr_data[NUM_MB-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxarb_irq.sv
module rxarb_irq #(
    parameter int NUM_MB = 32
) (
    input  logic [NUM_MB-1:0] pend,
    input  logic [NUM_MB-1:0] ien,
    input  logic [NUM_MB-1:0] lvl,
    output logic              irq0,
    output logic              irq1
);
    always_comb begin
        irq0 = 1'b0;
        irq1 = 1'b0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i] && ien[i]) begin
                if (lvl[i]) irq1 = 1'b1;
                else        irq0 = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_ovw_arbiter.sv
module rx_ovw_arbiter
    import rxarb_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [NUM_MB-1:0] match,
    input  logic [NUM_MB-1:0] clr_pend,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              store_vld,
    output logic [IDX_W-1:0]  store_idx,
    output logic              irq_line0,
    output logic              irq_line1
);
    pick_t             pick;
    logic [NUM_MB-1:0] pend_q, lost_q, prot_q, lvl_q, ien_q;

    rxarb_select #(.NUM_MB(NUM_MB)) u_sel (
        .match(match), .pend(pend_q), .prot(prot_q), .pick(pick)
    );

    assign store_vld = frame_vld & pick.hit;
    assign store_idx = pick.slot[IDX_W-1:0];

    rxarb_flags #(.NUM_MB(NUM_MB)) u_flags (
        .clk(clk), .rst(rst), .store_vld(store_vld), .store_slot(pick.slot),
        .store_ovw(pick.ovw), .clr(clr_pend), .pend_q(pend_q), .lost_q(lost_q)
    );

    rxarb_regs #(.NUM_MB(NUM_MB)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .prot_q(prot_q), .lvl_q(lvl_q), .ien_q(ien_q)
    );

    rxarb_irq #(.NUM_MB(NUM_MB)) u_irq (
        .pend(pend_q), .ien(ien_q), .lvl(lvl_q), .irq0(irq_line0), .irq1(irq_line1)
    );

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_PROT:  rd_data = REG_W'(prot_q);
            REG_LEVEL: rd_data = REG_W'(lvl_q);
            REG_IEN:   rd_data = REG_W'(ien_q);
            REG_PEND:  rd_data = REG_W'(pend_q);
            REG_LOST:  rd_data = REG_W'(lost_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rxarb_chk.sv
module rxarb_chk #(
    parameter int NUM_MB = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic [NUM_MB-1:0] match,
    input logic [NUM_MB-1:0] clr_pend,
    input logic              store_vld,
    input logic [IDX_W-1:0]  store_idx,
    input logic [NUM_MB-1:0] pend_q,
    input logic [NUM_MB-1:0] lost_q,
    input logic [NUM_MB-1:0] prot_q,
    input logic [NUM_MB-1:0] ien_q,
    input logic              irq_line0,
    input logic              irq_line1
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pend_q == '0 && lost_q == '0 && prot_q == '0)); // R1
    AST_STORE_ON_MATCH: assert property (@(posedge clk) disable iff (rst) store_vld |-> match[store_idx]); // R2
    AST_STORE_SETS_PEND: assert property (@(posedge clk) disable iff (rst) store_vld |=> pend_q[$past(store_idx)]); // R2
    AST_NO_PROTECTED_OVERWRITE: assert property (@(posedge clk) disable iff (rst) store_vld |-> !(pend_q[store_idx] && prot_q[store_idx])); // R3
    AST_OVERWRITE_LOST: assert property (@(posedge clk) disable iff (rst) (store_vld && pend_q[store_idx]) |=> lost_q[$past(store_idx)]); // R4
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst) (|clr_pend && !store_vld) |=> ((pend_q & $past(clr_pend)) == '0)); // R6
    AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (rst) ((pend_q & ien_q) == '0) |-> (!irq_line0 && !irq_line1)); // R7
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst) !frame_vld |-> !store_vld); // R9
endmodule

bind rx_ovw_arbiter rxarb_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .match(match), .clr_pend(clr_pend),
    .store_vld(store_vld), .store_idx(store_idx), .pend_q(pend_q), .lost_q(lost_q),
    .prot_q(prot_q), .ien_q(ien_q), .irq_line0(irq_line0), .irq_line1(irq_line1)
);

// File: tb/rx_ovw_arbiter_bench.sv
module rx_ovw_arbiter_bench;
    localparam int NMB = 4;
    localparam int IW  = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_vld = 1'b0;
    logic [NMB-1:0] match = '0;
    logic [NMB-1:0] clr_pend = '0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [3:0]     wr_be = '0;
    logic [31:0]    wr_data = '0;
    logic [2:0]     rd_addr = '0;
    logic [31:0]    rd_data;
    logic           store_vld;
    logic [IW-1:0]  store_idx;
    logic           irq_line0, irq_line1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_ovw_arbiter #(.NUM_MB(NMB)) u_rx_ovw_arbiter (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .match(match), .clr_pend(clr_pend),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .store_vld(store_vld), .store_idx(store_idx),
        .irq_line0(irq_line0), .irq_line1(irq_line1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        tick();
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic set_pending(input logic [NMB-1:0] p);
        clr_pend = '1;
        tick();
        clr_pend = '0;
        wr(3'd0, 32'h0, 4'hF);
        for (int i = 0; i < NMB; i++) begin
            if (p[i]) begin
                match = NMB'(1 << i); frame_vld = 1'b1;
                tick();
                frame_vld = 1'b0; match = '0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        rd_chk("R1", 3'd0, 0);
        rd_chk("R1", 3'd1, 0);
        rd_chk("R1", 3'd2, 0);
        rd_chk("R1", 3'd3, 0);
        rd_chk("R1", 3'd4, 0);
        chk("R1", {30'd0, irq_line1, irq_line0}, 0);

        // R8 byte-enable rejection and readback masking
        wr(3'd0, 32'hFFFF_FFFF, 4'h7);
        rd_chk("R8", 3'd0, 0);
        wr(3'd1, 32'hFFFF_FFFF, 4'h8);
        rd_chk("R8", 3'd1, 0);
        wr(3'd2, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R8", 3'd2, 32'hF);
        wr(3'd2, 32'h0, 4'hE);
        rd_chk("R8", 3'd2, 32'hF);
        wr(3'd2, 32'h0, 4'hF);

        // R9 idle frame strobe
        match = '1; frame_vld = 1'b0;
        #2 chk("R9", {31'd0, store_vld}, 0);
        tick();
        match = '0;
        rd_chk("R9", 3'd3, 0);

        // Exhaustive store decision sweep: R2 R3 R4 R5
        for (int p = 0; p < 16; p++) begin
            for (int pr = 0; pr < 16; pr++) begin
                for (int m = 0; m < 16; m++) begin
                    int w;
                    bit skipped;
                    string tag;
                    logic [31:0] ep, el;
                    set_pending(NMB'(p));
                    wr(3'd0, 32'(pr), 4'hF);
                    w = -1; skipped = 1'b0;
                    for (int i = 0; i < NMB; i++) begin
                        if (m[i] && !(p[i] && pr[i])) w = i;
                    end
                    for (int i = NMB - 1; i > w; i--) begin
                        if (m[i]) skipped = 1'b1;
                    end
                    if (w < 0)          tag = "R5";
                    else if (p[w])      tag = "R4";
                    else if (skipped)   tag = "R3";
                    else                tag = "R2";
                    ep = 32'(p); el = 0;
                    if (w >= 0) begin
                        ep[w] = 1'b1;
                        if (p[w]) el[w] = 1'b1;
                    end
                    match = NMB'(m); frame_vld = 1'b1;
                    #2;
                    chk(tag, {31'd0, store_vld}, (w >= 0) ? 1 : 0);
                    if (w >= 0) chk(tag, 32'(store_idx), 32'(w));
                    tick();
                    frame_vld = 1'b0; match = '0;
                    rd_chk(tag, 3'd3, ep);
                    rd_chk(tag, 3'd4, el);
                end
            end
        end

        // R6 clear alongside a store, then clear alone
        set_pending(4'b0010);
        clr_pend = 4'b0010; match = 4'b0010; frame_vld = 1'b1;
        tick();
        clr_pend = '0; match = '0; frame_vld = 1'b0;
        rd_chk("R6", 3'd3, 32'h2);
        rd_chk("R6", 3'd4, 32'h2);
        clr_pend = 4'b0010;
        tick();
        clr_pend = '0;
        rd_chk("R6", 3'd3, 0);
        rd_chk("R6", 3'd4, 0);

        // R7 interrupt routing sweep
        for (int p = 0; p < 16; p++) begin
            set_pending(NMB'(p));
            for (int lv = 0; lv < 16; lv++) begin
                wr(3'd1, 32'(lv), 4'hF);
                for (int en = 0; en < 16; en++) begin
                    wr(3'd2, 32'(en), 4'hF);
                    chk("R7", {31'd0, irq_line0}, ((p & en & ~lv & 15) != 0) ? 1 : 0);
                    chk("R7", {31'd0, irq_line1}, ((p & en & lv) != 0) ? 1 : 0);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule